// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block steps the CPU clock domain through a frequency change while the PLL that feeds it relocks. A pre-change request carries the old, new and alternate source rates. The block finds the divider words for the new rate in a table that is loaded beforehand. If running from the alternate source could push the CPU clock above the lower of the old and new rates, it first slows the core divider. It then moves the core mux to the alternate source and writes the new divider words. After each write or mux move, it waits for the matching status input before it goes on.

A post-change request moves the mux back to the PLL and resets the core divider. When the trace-divider option is on, the post-change request also restores the trace-bus divider from the table. Every wait has a timeout. When a wait times out, the block records an error and still carries on with the rest of the sequence. A request is taken only while `req_ready` is high. Each request is closed by a one-cycle `ack`, which carries an error bit and a warning bit.

Top module: `cpu_clk_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `ack`, `mux_sel`, both write strobes and both divider words are 0.
- R2: The table is scanned from entry 0 for a rate equal to the requested new rate. A pre-change request, or a post-change request with the trace option on, that first meets an entry of rate 0 (or runs off the end of the table) is acked with `ack_err`=1. Such a request produces no divider write and no mux change.
- R3: A pre-change request writes a safe divider first only when alt > old or old > new. Otherwise its first action is the mux switch.
- R4: The safe field is ceil(alt / min(old,new)) − 1. It is merged into bits 2:0 of divider word 0, and all other bits keep their values. With the trace option on, bits 18:16 are forced to 3'b111 in the same write.
- R5: When ceil(alt / min(old,new)) − 1 is 8 or more, `ack_warn` is 1 and the safe field is saturated to 7.
- R6: The pre-change order is: safe write (if any), then `mux_sel`=1, then wait for `mux_stat`==2. Next comes divider word 0, which is the table word OR the safe write's value when a safe write was made. Divider word 1 comes last. `div1_wr` only occurs while `mux_sel` is 1, and the two write strobes never fire together.
- R7: Divider word 1 takes the table value when `hpm_src` is 0. When `hpm_src` is 1, it becomes its current value masked with 32'h77.
- R8: The post-change order is: `mux_sel`=0, then wait for `mux_stat`==1. Next, one divider word 0 write clears bits 2:0 and loads bits 18:16 from the table entry; every other bit keeps its value.
- R9: A wait ends when its condition holds, or after 10·CYCLES_PER_MS cycles. The condition is one of: masked word-0 busy bits all 0; all word-1 busy bits 0; or `mux_stat` equal to the target. A timeout sets `ack_err`, and the remaining writes of the sequence still happen.
- R10: `req_ready` is 0 from the cycle after a request is accepted until the ack. `ack` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | log2(ENTRIES) | Table entry index |
| tbl_rate | input | RATE_W | Entry rate (0 marks end) |
| tbl_div0 | input | 32 | Entry divider word 0 |
| tbl_div1 | input | 32 | Entry divider word 1 |
| req_valid | input | 1 | Request strobe |
| req_post | input | 1 | 0 = pre-change, 1 = post-change |
| req_ready | output | 1 | Block idle, request accepted |
| old_rate | input | RATE_W | Current PLL rate |
| new_rate | input | RATE_W | Target PLL rate |
| alt_rate | input | RATE_W | Alternate source rate |
| hpm_src | input | 1 | Monitor clock not sourced from PLL |
| mux_stat | input | 3 | Mux status: 1 PLL, 2 alternate |
| div0_busy | input | 32 | Word 0 divider busy bits |
| div1_busy | input | 32 | Word 1 divider busy bits |
| mux_sel | output | 1 | Core mux select (1 = alternate) |
| div0_word | output | 32 | Divider word 0 value |
| div0_wr | output | 1 | Word 0 write strobe |
| div1_word | output | 32 | Divider word 1 value |
| div1_wr | output | 1 | Word 1 write strobe |
| ack | output | 1 | Request done pulse |
| ack_err | output | 1 | Lookup failure or wait timeout |
| ack_warn | output | 1 | Safe ratio out of range |

## Verification
The assertions assume the rate inputs are nonzero. They also assume the status inputs move only after the block has written or switched. The bench's responder raises busy bits or drops `mux_stat` to 0 on the half-cycle after each strobe or mux change, then settles them a few cycles later. Random requests draw the new rate from the loaded table, with an occasional absent rate. The alternate rate is kept at 50 or above, so the ratio stays finite. A freeze switch holds the busy bits high to drive the timeouts on purpose.

// File: rtl/cpu_clk_seq.sv
module cpu_clk_seq #(
  parameter int RATE_W        = 32,
  parameter int ENTRIES       = 16,
  parameter int CYCLES_PER_MS = 100,
  parameter bit TRACE_DIV     = 1'b1,
  parameter bit HAS_DIV1      = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tbl_we,
  input  logic [$clog2(ENTRIES)-1:0] tbl_addr,
  input  logic [RATE_W-1:0]          tbl_rate,
  input  logic [31:0]                tbl_div0,
  input  logic [31:0]                tbl_div1,
  input  logic                       req_valid,
  input  logic                       req_post,
  output logic                       req_ready,
  input  logic [RATE_W-1:0]          old_rate,
  input  logic [RATE_W-1:0]          new_rate,
  input  logic [RATE_W-1:0]          alt_rate,
  input  logic                       hpm_src,
  input  logic [2:0]                 mux_stat,
  input  logic [31:0]                div0_busy,
  input  logic [31:0]                div1_busy,
  output logic                       mux_sel,
  output logic [31:0]                div0_word,
  output logic                       div0_wr,
  output logic [31:0]                div1_word,
  output logic                       div1_wr,
  output logic                       ack,
  output logic                       ack_err,
  output logic                       ack_warn
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TO_LIMIT = 10 * CYCLES_PER_MS;
  localparam int TO_W = $clog2(TO_LIMIT + 1);
  localparam logic [31:0] TRACE_M = TRACE_DIV ? 32'h0007_0000 : 32'h0;
  localparam logic [31:0] SAFE_M = 32'h7 | TRACE_M;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_CALC, S_SAFE, S_MUX, S_D0, S_D1, S_PDIV, S_WAIT, S_DONE
  } st_t;

  logic [RATE_W-1:0] rate_m [ENTRIES];
  logic [31:0]       d0_m   [ENTRIES];
  logic [31:0]       d1_m   [ENTRIES];

  st_t st, ret;
  logic              post_q, err_q, warn_q;
  logic [IDX_W-1:0]  idx;
  logic [RATE_W-1:0] old_q, new_q, alt_q;
  logic [RATE_W+3:0] acc;
  logic [3:0]        k;
  logic [2:0]        sfield;
  logic [1:0]        wkind;
  logic [31:0]       wmask;
  logic [2:0]        wtarget;
  logic [TO_W-1:0]   cnt;

  wire [RATE_W-1:0] min_rate  = (old_q < new_q) ? old_q : new_q;
  wire              need      = (alt_q > old_q) || (old_q > new_q);
  wire [31:0]       safe_word = {29'b0, sfield} | TRACE_M;
  wire              wait_ok   = (wkind == 2'd0) ? ((div0_busy & wmask) == 32'b0) :
                                (wkind == 2'd1) ? (div1_busy == 32'b0) :
                                                  (mux_stat == wtarget);

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      rate_m[tbl_addr] <= tbl_rate;
      d0_m[tbl_addr]   <= tbl_div0;
      d1_m[tbl_addr]   <= tbl_div1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE;
      post_q <= 1'b0; err_q <= 1'b0; warn_q <= 1'b0;
      idx <= '0; old_q <= '0; new_q <= '0; alt_q <= '0;
      acc <= '0; k <= '0; sfield <= '0;
      wkind <= '0; wmask <= '0; wtarget <= '0; cnt <= '0;
      mux_sel <= 1'b0; div0_word <= '0; div1_word <= '0;
      div0_wr <= 1'b0; div1_wr <= 1'b0;
      ack <= 1'b0; ack_err <= 1'b0; ack_warn <= 1'b0;
    end else begin
      div0_wr <= 1'b0;
      div1_wr <= 1'b0;
      ack     <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          post_q <= req_post; err_q <= 1'b0; warn_q <= 1'b0;
          old_q <= old_rate; new_q <= new_rate; alt_q <= alt_rate;
          idx <= '0; acc <= '0; k <= '0; sfield <= '0;
          st <= (req_post && !TRACE_DIV) ? S_MUX : S_LOOK;
        end
        S_LOOK: begin
          if (rate_m[idx] == '0) begin
            err_q <= 1'b1; st <= S_DONE;
          end else if (rate_m[idx] == new_q) begin
            st <= post_q ? S_MUX : S_CALC;
          end else if (idx == IDX_W'(ENTRIES - 1)) begin
            err_q <= 1'b1; st <= S_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_CALC: begin
          if (!need) st <= S_MUX;
          else if ((acc < {4'b0, alt_q}) && (k < 4'd9)) begin
            acc <= acc + {4'b0, min_rate};
            k   <= k + 4'd1;
          end else begin
            sfield <= (k == 4'd0) ? 3'd0 : (k >= 4'd9) ? 3'd7 : 3'(k - 4'd1);
            warn_q <= (k >= 4'd9);
            st     <= S_SAFE;
          end
        end
        S_SAFE: begin
          div0_word <= (div0_word & ~SAFE_M) | (safe_word & SAFE_M);
          div0_wr <= 1'b1;
          wkind <= 2'd0; wmask <= SAFE_M; ret <= S_MUX; st <= S_WAIT;
        end
        S_MUX: begin
          mux_sel <= !post_q;
          wkind <= 2'd2; wtarget <= post_q ? 3'd1 : 3'd2;
          ret <= post_q ? S_PDIV : S_D0; st <= S_WAIT;
        end
        S_D0: begin
          div0_word <= d0_m[idx] | (need ? safe_word : 32'b0);
          div0_wr <= 1'b1;
          wkind <= 2'd0; wmask <= '1; ret <= HAS_DIV1 ? S_D1 : S_DONE; st <= S_WAIT;
        end
        S_D1: begin
          div1_word <= hpm_src ? (div1_word & 32'h77) : d1_m[idx];
          div1_wr <= 1'b1;
          wkind <= 2'd1; ret <= S_DONE; st <= S_WAIT;
        end
        S_PDIV: begin
          div0_word <= (div0_word & ~SAFE_M) | (TRACE_DIV ? (d0_m[idx] & TRACE_M) : 32'b0);
          div0_wr <= 1'b1;
          wkind <= 2'd0; wmask <= SAFE_M; ret <= S_DONE; st <= S_WAIT;
        end
        S_WAIT: begin
          if (wait_ok) begin
            cnt <= '0; st <= ret;
          end else if (cnt == TO_W'(TO_LIMIT - 1)) begin
            cnt <= '0; err_q <= 1'b1; st <= ret;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DONE: begin
          ack <= 1'b1; ack_err <= err_q; ack_warn <= warn_q; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R6
  div1_alt_chk: assert property (@(posedge clk) disable iff (!rst_n) div1_wr |-> mux_sel);
  // R6
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(div0_wr && div1_wr));
  // R9
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < TO_W'(TO_LIMIT));
  // R10
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |-> req_ready);
endmodule

// File: tb/test_cpu_clk_seq.sv
module test_cpu_clk_seq;
  localparam int CPM = 20;
  logic clk = 0, rst_n = 0;
  logic tbl_we = 0; logic [3:0] tbl_addr = 0;
  logic [31:0] tbl_rate = 0, tbl_div0 = 0, tbl_div1 = 0;
  logic req_valid = 0, req_post = 0, req_ready, hpm_src = 0;
  logic [31:0] old_rate = 0, new_rate = 0, alt_rate = 0;
  logic [2:0] mux_stat = 3'd1;
  logic [31:0] div0_busy = 0, div1_busy = 0;
  logic mux_sel, div0_wr, div1_wr, ack, ack_err, ack_warn;
  logic [31:0] div0_word, div1_word;

  cpu_clk_seq #(.RATE_W(32), .ENTRIES(16), .CYCLES_PER_MS(CPM)) i_cpu_clk_seq (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_rate(tbl_rate),
    .tbl_div0(tbl_div0), .tbl_div1(tbl_div1), .req_valid(req_valid), .req_post(req_post),
    .req_ready(req_ready), .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
    .hpm_src(hpm_src), .mux_stat(mux_stat), .div0_busy(div0_busy), .div1_busy(div1_busy),
    .mux_sel(mux_sel), .div0_word(div0_word), .div0_wr(div0_wr), .div1_word(div1_word),
    .div1_wr(div1_wr), .ack(ack), .ack_err(ack_err), .ack_warn(ack_warn));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  logic [31:0] t_rate [16], t_d0 [16], t_d1 [16];
  logic [31:0] md0 = 0, md1 = 0;
  int ev_n = 0; int ev_k [8]; logic [31:0] ev_v [8];
  int ex_n; int ex_k [8]; logic [31:0] ex_v [8];
  bit freeze = 0;
  localparam logic [31:0] TM = 32'h0007_0000, SM = 32'h0007_0007;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  initial begin : responder
    int b0 = 0, b1 = 0, mc = 0; logic last = 0;
    forever begin
      @(negedge clk);
      if (div0_wr) b0 = 3; else if (b0 > 0 && !freeze) b0--;
      if (div1_wr) b1 = 3; else if (b1 > 0 && !freeze) b1--;
      div0_busy = (b0 > 0) ? '1 : '0;
      div1_busy = (b1 > 0) ? '1 : '0;
      if (mux_sel !== last) begin mux_stat = 3'd0; mc = 4; last = mux_sel; end
      else if (mc > 0) begin mc--; if (mc == 0) mux_stat = mux_sel ? 3'd2 : 3'd1; end
      if (ev_n < 8) begin
        if (div0_wr) begin ev_k[ev_n] = 1; ev_v[ev_n] = div0_word; ev_n++; end
        if (div1_wr && ev_n < 8) begin ev_k[ev_n] = 2; ev_v[ev_n] = div1_word; ev_n++; end
      end
    end
  end

  logic mux_prev = 0;
  always @(negedge clk) begin
    if (mux_sel !== mux_prev && ev_n < 8) begin ev_k[ev_n] = 3; ev_v[ev_n] = {31'b0, mux_sel}; ev_n++; end
    mux_prev = mux_sel;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic int find(logic [31:0] r);
    for (int i = 0; i < 16; i++) begin
      if (t_rate[i] == 0) return -1;
      if (t_rate[i] == r) return i;
    end
    return -1;
  endfunction

  task automatic push(int k, logic [31:0] v);
    ex_k[ex_n] = k; ex_v[ex_n] = v; ex_n++;
  endtask

  task automatic run(bit post, logic [31:0] o, logic [31:0] n, logic [31:0] a, bit h, bit exp_to);
    int e; bit need, w; logic [31:0] m, c, f, sw; bit exp_err;
    string tg;
    ex_n = 0; w = 0;
    e = find(n);
    exp_err = (e < 0) || exp_to;
    if (e >= 0 && !post) begin
      need = (a > o) || (o > n);
      m = (o < n) ? o : n;
      c = (a + m - 1) / m;
      w = need && (c - 1 >= 8);
      f = w ? 7 : c - 1;
      sw = need ? (f | TM) : 32'h0;
      if (need) begin md0 = (md0 & ~SM) | (sw & SM); push(1, md0); end
      push(3, 1);
      md0 = t_d0[e] | sw; push(1, md0);
      md1 = h ? (md1 & 32'h77) : t_d1[e]; push(2, md1);
    end else if (e >= 0) begin
      push(3, 0);
      md0 = (md0 & ~SM) | (t_d0[e] & TM); push(1, md0);
    end
    tg = post ? "R8" : "R6";
    @(negedge clk);
    ev_n = 0;
    req_post = post; old_rate = o; new_rate = n; alt_rate = a; hpm_src = h; req_valid = 1;
    @(negedge clk); req_valid = 0;
    chk(!req_ready, "R10 ready low while busy", {31'b0, req_ready}, 0);
    for (int i = 0; i < 5000 && !ack; i++) @(negedge clk);
    chk(ack, "R10 ack seen", {31'b0, ack}, 1);
    chk(ack_err == exp_err, (e < 0) ? "R2 lookup error" : (exp_to ? "R9 timeout error" : "R9 no error"),
        {31'b0, ack_err}, {31'b0, exp_err});
    if (!post) chk(ack_warn == w, "R5 warn", {31'b0, ack_warn}, {31'b0, w});
    @(negedge clk);
    chk(!ack, "R10 ack one cycle", {31'b0, ack}, 0);
    chk(ev_n == ex_n, (e < 0) ? "R2 no writes" : "R3 event count", ev_n, ex_n);
    for (int i = 0; i < ex_n && i < ev_n; i++) begin
      chk(ev_k[i] == ex_k[i] && ev_v[i] == ex_v[i],
          (ex_k[i] == 2) ? "R7 div1 value" : (i == 0 && ex_k[i] == 1) ? "R4 safe write" : tg,
          ev_v[i] ^ (ev_k[i] << 28), ex_v[i] ^ (ex_k[i] << 28));
    end
  endtask

  initial begin : main
    int cur; logic [31:0] nr, ar;
    void'($urandom(12345));
    repeat (3) @(negedge clk);
    chk(req_ready && !ack && !mux_sel && !div0_wr && !div1_wr && div0_word == 0 && div1_word == 0,
        "R1 reset state", div0_word | div1_word, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mux_sel, "R1 ready after reset", {31'b0, req_ready}, 1);
    for (int i = 0; i < 16; i++) begin
      t_rate[i] = (i < 8) ? 32'(100 * (i + 1)) : 0;
      t_d0[i] = $urandom; t_d1[i] = $urandom;
      tbl_we = 1; tbl_addr = 4'(i); tbl_rate = t_rate[i]; tbl_div0 = t_d0[i]; tbl_div1 = t_d1[i];
      @(negedge clk);
    end
    tbl_we = 0;
    // R3: no safe divider needed (alt below old, rising)
    run(0, 400, 600, 300, 0, 0); run(1, 400, 600, 300, 0, 0);
    // R5: ratio exactly 8 -> field 7 no warn; ratio 9 -> warn
    run(0, 600, 100, 800, 1, 0); run(1, 600, 100, 800, 0, 0);
    run(0, 100, 800, 900, 0, 0); run(1, 100, 800, 900, 0, 0);
    // R2: absent rate
    run(0, 800, 150, 500, 0, 0); run(1, 800, 150, 500, 0, 0);
    // R9: frozen busy bits force timeouts, sequence still completes
    freeze = 1; run(0, 800, 300, 500, 0, 1); freeze = 0;
    run(1, 800, 300, 500, 0, 0);
    cur = 300;
    for (int it = 0; it < 30; it++) begin
      nr = ($urandom_range(9) == 0) ? 32'd250 : 32'(100 * ($urandom_range(7) + 1));
      ar = 32'($urandom_range(900, 50));
      run(0, cur, nr, ar, 1'($urandom_range(1)), 0);
      run(1, cur, nr, ar, 0, 0);
      if (find(nr) >= 0) cur = nr;
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule